// File: doc/BRIEF.md
# Interrupt Return Address Capture

This block keeps a register holding the address of the instruction that will retire next, and uses it to record a precise return address when an asynchronous interrupt is accepted. Each retirement moves the register past the retired instruction. A branch or jump flush moves it to the flush target. Because of this, the register never holds the address of a wrong-path instruction that was fetched or decoded behind a jump.

The block accepts an interrupt request only while the global enable is set. It then waits before it saves the return address. It waits until no instruction retires and no flush occurs in that cycle, until any CSR modification already under way has finished, and until the pipeline reports that it is drained. When all of these hold, it latches the return address and gives a one-cycle capture strobe. The interrupt-taken pulse, which redirects fetch, follows in the next cycle. The two outputs are plain strobes with no back-pressure: the consumer must take them in the cycle they appear.

Top module: `irq_return_capture`

## Requirements
- R1: After reset, the next-to-retire address equals the parameter RESET_VEC. Both strobes are low and no capture is pending. A capture with no intervening retire or flush saves RESET_VEC.
- R2: When `retire_valid` is high and `flush_valid` is low, the next-to-retire address becomes `retire_pc + 4` if `retire_wide` is 1, or `retire_pc + 2` if `retire_wide` is 0.
- R3: When `flush_valid` is high, the next-to-retire address becomes `flush_target`. This holds even if a retirement happens in the same cycle. Addresses of wrong-path instructions are therefore never saved.
- R4: An interrupt request is accepted only in a cycle where both `irq_req` and `irq_enable` are high and no capture is pending. While `irq_enable` is low, a request has no effect on either strobe.
- R5: After acceptance, capture is delayed through every cycle with `retire_valid` or `flush_valid` high. The saved address points past the last retired instruction.
- R6: Capture is delayed while `csr_busy` is high. The saved address follows the CSR instruction that retires when its modification completes.
- R7: Capture is delayed while `pipe_drained` is low.
- R8: `cap_done` is high for exactly one cycle, and `mepc` holds the new address in that same cycle. `irq_taken` is high exactly in the following cycle, never at any other time.
- R9: If `irq_req` falls after acceptance, the pending capture still completes.
- R10: `mepc` changes only in the cycle in which `cap_done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 1 | Asynchronous interrupt request (level) |
| irq_enable | input | 1 | Global interrupt enable |
| retire_valid | input | 1 | An instruction retires this cycle |
| retire_pc | input | XLEN | Address of the retiring instruction |
| retire_wide | input | 1 | 1: 4-byte instruction, 0: 2-byte instruction |
| flush_valid | input | 1 | Branch or jump flush this cycle |
| flush_target | input | XLEN | Address of the flush target |
| csr_busy | input | 1 | A CSR modification is in progress |
| pipe_drained | input | 1 | No issued instruction remains in flight |
| mepc | output | XLEN | Captured return address |
| cap_done | output | 1 | One-cycle strobe: `mepc` was just loaded |
| irq_taken | output | 1 | One-cycle pulse to redirect fetch to the handler |

## Verification
The assertions assume that every input is a known value in each cycle after reset. They also assume that `flush_target` is meaningful whenever `flush_valid` is high. No assumption is made about how the inputs relate to one another: a retirement together with a flush, or a retirement while the pipeline claims to be drained, is treated as legal. The stimulus drives every input on each falling edge. Random traffic freely mixes retirements, flushes, CSR activity, drain status and enable toggling, and directed sequences hold each delay condition high across several cycles.

// File: rtl/irq_cap_pkg.sv
package irq_cap_pkg;
  typedef enum logic [1:0] {
    CAP_IDLE = 2'd0,
    CAP_WAIT = 2'd1,
    CAP_TAKE = 2'd2
  } cap_state_e;
endpackage

// File: rtl/retire_pc_tracker.sv
module retire_pc_tracker #(
  parameter int unsigned XLEN         = 32,
  parameter logic [XLEN-1:0] RESET_VEC = 32'h0000_0100,
  parameter bit HALF_STEP_EN          = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            retire_valid,
  input  logic [XLEN-1:0] retire_pc,
  input  logic            retire_wide,
  input  logic            flush_valid,
  input  logic [XLEN-1:0] flush_target,
  output logic [XLEN-1:0] next_pc
);
  localparam logic [XLEN-1:0] WIDE_STEP = XLEN'(4);
  localparam logic [XLEN-1:0] HALF_STEP = XLEN'(2);

  logic [XLEN-1:0] step;

  generate
    if (HALF_STEP_EN) begin : g_mixed
      assign step = retire_wide ? WIDE_STEP : HALF_STEP;
    end else begin : g_fixed
      logic unused_wide;
      assign unused_wide = retire_wide;
      assign step = WIDE_STEP;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      next_pc <= RESET_VEC;
    end else if (flush_valid) begin
      next_pc <= flush_target;
    end else if (retire_valid) begin
      next_pc <= retire_pc + step;
    end
  end
endmodule

// File: rtl/capture_fsm.sv
module capture_fsm
  import irq_cap_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            irq_req,
  input  logic            irq_enable,
  input  logic            retire_valid,
  input  logic            flush_valid,
  input  logic            csr_busy,
  input  logic            pipe_drained,
  input  logic [XLEN-1:0] next_pc,
  output logic [XLEN-1:0] mepc,
  output logic            cap_done,
  output logic            irq_taken
);
  cap_state_e state_q, state_d;
  logic accept, settled;

  assign accept  = irq_req & irq_enable;
  // nothing may move the tracker in the capture cycle
  assign settled = ~retire_valid & ~flush_valid & ~csr_busy & pipe_drained;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      CAP_IDLE: if (accept)  state_d = CAP_WAIT;
      CAP_WAIT: if (settled) state_d = CAP_TAKE;
      CAP_TAKE:              state_d = CAP_IDLE;
      default:               state_d = CAP_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= CAP_IDLE;
      mepc      <= '0;
      cap_done  <= 1'b0;
      irq_taken <= 1'b0;
    end else begin
      state_q   <= state_d;
      cap_done  <= (state_q == CAP_WAIT) && settled;
      irq_taken <= (state_q == CAP_TAKE);
      if ((state_q == CAP_WAIT) && settled) mepc <= next_pc;
    end
  end
endmodule

// File: rtl/irq_return_capture.sv
module irq_return_capture #(
  parameter int unsigned XLEN          = 32,
  parameter logic [XLEN-1:0] RESET_VEC = 32'h0000_0100,
  parameter bit HALF_STEP_EN           = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            irq_req,
  input  logic            irq_enable,
  input  logic            retire_valid,
  input  logic [XLEN-1:0] retire_pc,
  input  logic            retire_wide,
  input  logic            flush_valid,
  input  logic [XLEN-1:0] flush_target,
  input  logic            csr_busy,
  input  logic            pipe_drained,
  output logic [XLEN-1:0] mepc,
  output logic            cap_done,
  output logic            irq_taken
);
  logic [XLEN-1:0] next_pc;

  retire_pc_tracker #(
    .XLEN(XLEN), .RESET_VEC(RESET_VEC), .HALF_STEP_EN(HALF_STEP_EN)
  ) u_trk (
    .clk(clk), .rst_n(rst_n),
    .retire_valid(retire_valid), .retire_pc(retire_pc), .retire_wide(retire_wide),
    .flush_valid(flush_valid), .flush_target(flush_target),
    .next_pc(next_pc)
  );

  capture_fsm #(.XLEN(XLEN)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .irq_req(irq_req), .irq_enable(irq_enable),
    .retire_valid(retire_valid), .flush_valid(flush_valid),
    .csr_busy(csr_busy), .pipe_drained(pipe_drained),
    .next_pc(next_pc),
    .mepc(mepc), .cap_done(cap_done), .irq_taken(irq_taken)
  );
endmodule

// File: rtl/irq_return_capture_chk.sv
module irq_return_capture_chk #(
  parameter int unsigned XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            retire_valid,
  input logic            flush_valid,
  input logic [XLEN-1:0] flush_target,
  input logic            csr_busy,
  input logic            pipe_drained,
  input logic [XLEN-1:0] next_pc,
  input logic [XLEN-1:0] mepc,
  input logic            cap_done,
  input logic            irq_taken
);
  // R3
  flush_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |=> (next_pc == $past(flush_target)));
  // R5
  no_retire_at_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_done |-> $past(!retire_valid && !flush_valid));
  // R6
  csr_settled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_done |-> $past(!csr_busy));
  // R7
  drained_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_done |-> $past(pipe_drained));
  // R8
  taken_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_done |=> (irq_taken && !cap_done));
  // R8
  taken_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_taken |-> $past(cap_done));
  // R10
  mepc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_done |-> $stable(mepc));
endmodule

bind irq_return_capture irq_return_capture_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .retire_valid(retire_valid), .flush_valid(flush_valid),
  .flush_target(flush_target), .csr_busy(csr_busy),
  .pipe_drained(pipe_drained), .next_pc(next_pc),
  .mepc(mepc), .cap_done(cap_done), .irq_taken(irq_taken)
);

// File: tb/sim_irq_return_capture.sv
module sim_irq_return_capture;
  localparam int unsigned XLEN = 32;
  localparam logic [31:0] RVEC = 32'h0000_0100;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic irq_req = 0, irq_enable = 0, retire_valid = 0, retire_wide = 0;
  logic flush_valid = 0, csr_busy = 0, pipe_drained = 0;
  logic [31:0] retire_pc = '0, flush_target = '0;
  logic [31:0] mepc;
  logic cap_done, irq_taken;

  int checks = 0, errors = 0;
  string tag = "R1";

  // reference state
  logic [31:0] m_trk = RVEC, m_mepc = '0;
  logic m_done = 0, m_taken = 0;
  int m_st = 0; // 0 idle, 1 waiting, 2 taking

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_return_capture #(.XLEN(XLEN), .RESET_VEC(RVEC)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_enable(irq_enable),
    .retire_valid(retire_valid), .retire_pc(retire_pc), .retire_wide(retire_wide),
    .flush_valid(flush_valid), .flush_target(flush_target),
    .csr_busy(csr_busy), .pipe_drained(pipe_drained),
    .mepc(mepc), .cap_done(cap_done), .irq_taken(irq_taken)
  );

  function automatic logic [31:0] exp_next(input logic [31:0] cur, input logic rv,
      input logic [31:0] pc, input logic wide, input logic fl, input logic [31:0] tgt);
    if (fl) return tgt;
    if (rv) return pc + (wide ? 32'd4 : 32'd2);
    return cur;
  endfunction

  function automatic logic ready_to_save(input logic rv, input logic fl,
      input logic csr, input logic drn);
    return !rv && !fl && !csr && drn;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: drive at a falling edge, model at the rising edge, compare at the next falling edge
  task automatic cyc(input logic irq, input logic ie, input logic rv, input logic [31:0] pc,
      input logic wide, input logic fl, input logic [31:0] tgt, input logic csr, input logic drn);
    irq_req = irq; irq_enable = ie; retire_valid = rv; retire_pc = pc; retire_wide = wide;
    flush_valid = fl; flush_target = tgt; csr_busy = csr; pipe_drained = drn;
    @(posedge clk);
    m_done = 0; m_taken = 0;
    case (m_st)
      0: if (irq && ie) m_st = 1;
      1: if (ready_to_save(rv, fl, csr, drn)) begin m_mepc = m_trk; m_done = 1; m_st = 2; end
      default: begin m_taken = 1; m_st = 0; end
    endcase
    m_trk = exp_next(m_trk, rv, pc, wide, fl, tgt);
    @(negedge clk);
    check({tag, " cap_done"}, {31'd0, cap_done}, {31'd0, m_done});
    check("R8 irq_taken", {31'd0, irq_taken}, {31'd0, m_taken});
    check({tag, " R10 mepc"}, mepc, m_mepc);
  endtask

  task automatic idle(input int n, input logic irq, input logic ie);
    for (int i = 0; i < n; i++) cyc(irq, ie, 0, '0, 0, 0, '0, 0, 1);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    tag = "R1";
    check("R1 reset cap_done", {31'd0, cap_done}, 32'd0);
    check("R1 reset irq_taken", {31'd0, irq_taken}, 32'd0);
    check("R1 reset mepc", mepc, 32'd0);
    rst_n = 1'b1;
    cyc(1, 1, 0, '0, 0, 0, '0, 0, 1);
    idle(3, 0, 0);                       // capture of RESET_VEC
    check("R1 saved reset vector", mepc, RVEC);

    tag = "R4";
    idle(6, 1, 0);                       // enable low: nothing happens

    tag = "R2";
    cyc(0, 0, 1, 32'h200, 1, 0, '0, 0, 0);
    cyc(0, 0, 1, 32'h204, 0, 0, '0, 0, 0);
    cyc(1, 1, 0, '0, 0, 0, '0, 0, 1);
    idle(3, 0, 0);
    check("R2 step 4 then 2", mepc, 32'h206);

    tag = "R3";
    cyc(0, 0, 1, 32'h300, 1, 1, 32'h400, 0, 0);  // jump retires with flush
    cyc(1, 1, 0, '0, 0, 0, '0, 0, 1);
    idle(3, 0, 0);
    check("R3 flush target saved", mepc, 32'h400);

    tag = "R5";
    cyc(1, 1, 0, '0, 0, 0, '0, 0, 1);
    cyc(0, 1, 1, 32'h400, 1, 0, '0, 0, 1);
    cyc(0, 1, 1, 32'h404, 1, 0, '0, 0, 1);
    idle(3, 0, 1);
    check("R5 past last retire", mepc, 32'h408);

    tag = "R6";
    cyc(1, 1, 0, '0, 0, 0, '0, 1, 1);
    cyc(0, 1, 0, '0, 0, 0, '0, 1, 1);
    cyc(0, 1, 0, '0, 0, 0, '0, 1, 1);
    cyc(0, 1, 1, 32'h408, 1, 0, '0, 0, 1);       // CSR instruction retires
    idle(3, 0, 0);
    check("R6 after csr instr", mepc, 32'h40c);

    tag = "R7";
    cyc(1, 1, 0, '0, 0, 0, '0, 0, 0);
    for (int i = 0; i < 4; i++) cyc(0, 1, 0, '0, 0, 0, '0, 0, 0);
    tag = "R9";                          // request dropped, capture still done
    idle(3, 0, 0);
    check("R9 capture completed", mepc, 32'h40c);

    tag = "R8";
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] pc, tg;
      pc = $urandom & 32'hffff_fffe;
      tg = $urandom & 32'hffff_fffe;
      cyc(($urandom % 8) == 0, ($urandom % 4) != 0, $urandom % 2, pc, $urandom % 2,
          ($urandom % 8) == 0, tg, ($urandom % 4) == 0, $urandom % 2);
    end
    idle(4, 0, 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule